// File: doc/BRIEF.md
# Block-Shared Sparsity Indication Encoder

This encoder compresses the post-activation outputs of eight channels for a sparse convolution engine. Each step takes a block of two spatially adjacent positions from every channel. Half A and half B each present one value per channel. For each half, the block builds an 8-bit nonzero pattern with one bit per channel. It sends the nonzero values, compacted, to a value stream and drops the zeros.

The two patterns go to an indication stream. When the two patterns are equal, only the first is written. A per-block mark bit records whether the block was merged. These marks are collected eight to a byte for a mark table. A frame-end flag on the final block flushes any partly filled mark byte.

A block is accepted through a valid/ready handshake and takes two cycles. The cycle after acceptance carries half A's pattern, half A's values and any completed mark byte. The cycle after that carries half B's values and, if the halves differ, half B's pattern.

Top module: `sparse_ind_encoder`

## Requirements
- R1: After reset, `ind_we` is 0, `val_cnt` is 0, `mark_vld` is 0 and `blk_ready` is 1.
- R2: Channel c of a half occupies bits [c*8 +: 8] of `blk_row_a`/`blk_row_b`. Bit c of its pattern is 1 when that value is nonzero and 0 when it is zero.
- R3: A block is accepted when `blk_valid` and `blk_ready` are both 1 at a clock edge. `blk_ready` is then 0 for exactly one cycle, so each block occupies two cycles.
- R4: In the cycle after acceptance, `ind_we` is 1 and `ind_data` holds half A's pattern.
- R5: In the second cycle after acceptance, `ind_we` is 1 with half B's pattern when the two patterns differ. It is 0 when the two patterns are equal.
- R6: In the first output cycle, `val_data` carries half A's nonzero values packed from lane 0 upward in ascending channel order, and `val_cnt` gives their count. The second output cycle does the same for half B. Lanes at or above `val_cnt` read zero.
- R7: A block's mark bit is 1 exactly when its two patterns are bitwise equal.
- R8: Marks fill `mark_byte` from bit 0 upward in block order. `mark_vld` pulses for one cycle, in the first output cycle of the eighth block of a byte.
- R9: A block accepted with `blk_last`=1 ends the byte early. A partial byte is emitted with its unfilled bits 0, and the next block's mark lands in bit 0.
- R10: When `blk_last` arrives with the block that fills a byte, exactly one byte is emitted.
- R11: With `blk_valid` at 0, no indication write is made, `val_cnt` stays 0 and no mark byte is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | Block offered |
| blk_ready | output | 1 | Block can be accepted this cycle |
| blk_row_a | input | 64 | Half A values, 8 bits per channel |
| blk_row_b | input | 64 | Half B values, 8 bits per channel |
| blk_last | input | 1 | Final block of the frame; flush marks |
| ind_we | output | 1 | Indication store write enable |
| ind_data | output | 8 | Indication pattern, one bit per channel |
| val_data | output | 64 | Compacted nonzero values, lane 0 first |
| val_cnt | output | 4 | Number of valid value lanes |
| mark_byte | output | 8 | Packed mark bits |
| mark_vld | output | 1 | Mark byte valid pulse |

## Verification
A completed mark byte is emitted in the same cycle as half A's pattern write and half A's value burst. The bench checks all three together, in that cycle, after every eighth block. The sharper collision is a frame end arriving on the block that fills the byte. There the natural fill and the flush coincide, and this is provoked by sending eight blocks with the flag on the last one. The bench judges it by requiring a single `mark_vld` pulse with the full byte and a clean restart at bit 0 on the next block.

// File: rtl/spind_pkg.sv
package spind_pkg;
    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;
endpackage

// File: rtl/spind_zero_detect.sv
module spind_zero_detect #(
    parameter int CH = 8,
    parameter int DW = 8
) (
    input  logic [CH*DW-1:0] row,
    output logic [CH-1:0]    pattern
);
    for (genvar c = 0; c < CH; c++) begin : g_cmp
        assign pattern[c] = |row[c*DW +: DW];
    end
endmodule

// File: rtl/spind_value_packer.sv
module spind_value_packer #(
    parameter int CH   = 8,
    parameter int DW   = 8,
    localparam int CNTW = $clog2(CH + 1)
) (
    input  logic [CH*DW-1:0] row,
    input  logic [CH-1:0]    pattern,
    output logic [CH*DW-1:0] packed_vals,
    output logic [CNTW-1:0]  count
);
    logic [DW-1:0] lane [CH];
    int            pos;

    always_comb begin
        pos = 0;
        for (int l = 0; l < CH; l++) lane[l] = '0;
        for (int c = 0; c < CH; c++) begin
            if (pattern[c]) begin
                lane[pos] = row[c*DW +: DW];
                pos       = pos + 1;
            end
        end
        count = CNTW'(pos);
    end

    for (genvar l = 0; l < CH; l++) begin : g_out
        assign packed_vals[l*DW +: DW] = lane[l];
    end

    always_comb begin
        assert (int'(count) == $countones(pattern))
            else $error("p_count_matches_pattern_r6");
    end
endmodule

// File: rtl/spind_mark_packer.sv
module spind_mark_packer #(
    parameter int MW = 8,
    localparam int CW = $clog2(MW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          mark,
    input  logic          last,
    output logic [MW-1:0] byte_out,
    output logic          byte_vld
);
    typedef struct packed {
        logic [MW-1:0] acc;
        logic [CW-1:0] cnt;
        logic [MW-1:0] outb;
        logic          vld;
    } mp_t;

    mp_t s_d, s_q;
    logic [MW-1:0] acc_next;

    always_comb begin
        s_d      = s_q;
        s_d.vld  = 1'b0;
        acc_next = s_q.acc | (MW'(mark) << s_q.cnt);
        if (push) begin
            if (s_q.cnt == CW'(MW - 1) || last) begin
                s_d.outb = acc_next;
                s_d.vld  = 1'b1;
                s_d.acc  = '0;
                s_d.cnt  = '0;
            end else begin
                s_d.acc = acc_next;
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign byte_out = s_q.outb;
    assign byte_vld = s_q.vld;

    p_no_back_to_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);
    p_single_emit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> s_q.cnt == '0);
endmodule

// File: rtl/sparse_ind_encoder.sv
module sparse_ind_encoder
    import spind_pkg::*;
#(
    parameter int CH = 8,
    parameter int DW = 8,
    localparam int CNTW = $clog2(CH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_valid,
    output logic             blk_ready,
    input  logic [CH*DW-1:0] blk_row_a,
    input  logic [CH*DW-1:0] blk_row_b,
    input  logic             blk_last,
    output logic             ind_we,
    output logic [CH-1:0]    ind_data,
    output logic [CH*DW-1:0] val_data,
    output logic [CNTW-1:0]  val_cnt,
    output logic [CH-1:0]    mark_byte,
    output logic             mark_vld
);
    typedef struct packed {
        phase_e              phase;
        logic [CH-1:0]       hold_pat;
        logic [CH*DW-1:0]    hold_vals;
        logic [CNTW-1:0]     hold_cnt;
        logic                hold_mark;
        logic                we;
        logic [CH-1:0]       pat;
        logic [CH*DW-1:0]    vals;
        logic [CNTW-1:0]     cnt;
    } st_t;

    st_t s_d, s_q;

    logic [CH*DW-1:0] rows   [2];
    logic [CH-1:0]    pats   [2];
    logic [CH*DW-1:0] pvals  [2];
    logic [CNTW-1:0]  pcnt   [2];
    logic             accept;
    logic             mark;

    assign rows[0] = blk_row_a;
    assign rows[1] = blk_row_b;

    for (genvar r = 0; r < 2; r++) begin : g_half
        spind_zero_detect #(.CH(CH), .DW(DW)) u_zd (
            .row     (rows[r]),
            .pattern (pats[r])
        );
        spind_value_packer #(.CH(CH), .DW(DW)) u_pk (
            .row         (rows[r]),
            .pattern     (pats[r]),
            .packed_vals (pvals[r]),
            .count       (pcnt[r])
        );
    end

    assign blk_ready = (s_q.phase == PH_FIRST);
    assign accept    = blk_valid && blk_ready;
    assign mark      = &(~(pats[0] ^ pats[1]));

    always_comb begin
        s_d     = s_q;
        s_d.we  = 1'b0;
        s_d.cnt = '0;
        s_d.vals = '0;
        if (s_q.phase == PH_SECOND) begin
            s_d.phase = PH_FIRST;
            s_d.we    = !s_q.hold_mark;
            s_d.pat   = s_q.hold_pat;
            s_d.vals  = s_q.hold_vals;
            s_d.cnt   = s_q.hold_cnt;
        end else if (accept) begin
            s_d.phase     = PH_SECOND;
            s_d.we        = 1'b1;
            s_d.pat       = pats[0];
            s_d.vals      = pvals[0];
            s_d.cnt       = pcnt[0];
            s_d.hold_pat  = pats[1];
            s_d.hold_vals = pvals[1];
            s_d.hold_cnt  = pcnt[1];
            s_d.hold_mark = mark;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    spind_mark_packer #(.MW(CH)) u_mark (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (accept),
        .mark     (mark),
        .last     (blk_last),
        .byte_out (mark_byte),
        .byte_vld (mark_vld)
    );

    assign ind_we   = s_q.we;
    assign ind_data = s_q.pat;
    assign val_data = s_q.vals;
    assign val_cnt  = s_q.cnt;

    p_one_cycle_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !blk_ready ##1 blk_ready);
    p_first_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ind_we);
    p_second_differs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 (ind_we -> ind_data != $past(ind_data)));
    p_count_in_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_SECOND) |-> (int'(val_cnt) == $countones(ind_data)));
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_ready && !blk_valid) |=> !ind_we && val_cnt == '0 && !mark_vld);
endmodule

// File: tb/sim_sparse_ind_encoder.sv
module sim_sparse_ind_encoder;
    localparam int CH = 8;
    localparam int DW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blk_valid = 1'b0;
    logic        blk_ready;
    logic [63:0] blk_row_a = '0;
    logic [63:0] blk_row_b = '0;
    logic        blk_last = 1'b0;
    logic        ind_we;
    logic [7:0]  ind_data;
    logic [63:0] val_data;
    logic [3:0]  val_cnt;
    logic [7:0]  mark_byte;
    logic        mark_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] mb_acc = '0;
    int         mb_cnt = 0;

    always #2 clk = ~clk;

    sparse_ind_encoder #(.CH(CH), .DW(DW)) u0 (
        .clk, .rst_n, .blk_valid, .blk_ready, .blk_row_a, .blk_row_b,
        .blk_last, .ind_we, .ind_data, .val_data, .val_cnt,
        .mark_byte, .mark_vld
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mkrow(input logic [7:0] mask, input logic [7:0] base);
        logic [63:0] r = '0;
        for (int c = 0; c < 8; c++)
            if (mask[c]) r[c*8 +: 8] = base + 8'(c * 17 + 1);
        return r;
    endfunction

    function automatic logic [7:0] pat_of(input logic [63:0] r);
        logic [7:0] p;
        for (int c = 0; c < 8; c++) p[c] = |r[c*8 +: 8];
        return p;
    endfunction

    function automatic logic [63:0] pack_of(input logic [63:0] r);
        logic [63:0] o = '0;
        int k = 0;
        for (int c = 0; c < 8; c++)
            if (|r[c*8 +: 8]) begin
                o[k*8 +: 8] = r[c*8 +: 8];
                k++;
            end
        return o;
    endfunction

    // Called just after a negedge with blk_ready expected high.
    task automatic send(input logic [63:0] ra, input logic [63:0] rb, input bit last);
        logic [7:0] pa = pat_of(ra);
        logic [7:0] pb = pat_of(rb);
        bit         mk = (pa == pb);
        bit         emit;
        logic [7:0] exp_byte;
        chk(blk_ready == 1'b1, "R3 ready before block", 64'(blk_ready), 64'd1);
        blk_row_a = ra; blk_row_b = rb; blk_last = last; blk_valid = 1'b1;
        mb_acc[mb_cnt] = mk;
        mb_cnt++;
        emit     = (mb_cnt == 8) || last;
        exp_byte = mb_acc;
        if (emit) begin mb_acc = '0; mb_cnt = 0; end
        @(negedge clk);
        blk_valid = 1'b0; blk_last = 1'b0;
        chk(blk_ready == 1'b0, "R3 ready low after accept", 64'(blk_ready), 64'd0);
        chk(ind_we == 1'b1, "R4 first write enable", 64'(ind_we), 64'd1);
        chk(ind_data == pa, "R2 R4 first pattern", 64'(ind_data), 64'(pa));
        chk(val_data == pack_of(ra), "R6 half A values", val_data, pack_of(ra));
        chk(val_cnt == 4'($countones(pa)), "R6 half A count", 64'(val_cnt), 64'($countones(pa)));
        chk(mark_vld == emit, "R8 R9 R10 mark valid", 64'(mark_vld), 64'(emit));
        if (emit)
            chk(mark_byte == exp_byte, "R7 R8 R9 mark byte", 64'(mark_byte), 64'(exp_byte));
        @(negedge clk);
        chk(ind_we == !mk, "R5 second write enable", 64'(ind_we), 64'(!mk));
        if (!mk) chk(ind_data == pb, "R5 second pattern", 64'(ind_data), 64'(pb));
        chk(val_data == pack_of(rb), "R6 half B values", val_data, pack_of(rb));
        chk(val_cnt == 4'($countones(pb)), "R6 half B count", 64'(val_cnt), 64'($countones(pb)));
        chk(mark_vld == 1'b0, "R10 single mark pulse", 64'(mark_vld), 64'd0);
    endtask

    task automatic t_reset();
        chk(ind_we == 1'b0, "R1 reset we", 64'(ind_we), 64'd0);
        chk(val_cnt == '0, "R1 reset count", 64'(val_cnt), 64'd0);
        chk(mark_vld == 1'b0, "R1 reset mark valid", 64'(mark_vld), 64'd0);
        chk(blk_ready == 1'b1, "R1 reset ready", 64'(blk_ready), 64'd1);
    endtask

    task automatic t_patterns();
        send(mkrow(8'hA5, 8'h10), mkrow(8'h5A, 8'h20), 1'b0);
        send(mkrow(8'h3C, 8'h80), mkrow(8'h3C, 8'h40), 1'b0);
        send(64'h0, 64'h0, 1'b0);
        send(mkrow(8'hFF, 8'h01), mkrow(8'hFF, 8'hF0), 1'b0);
        send(mkrow(8'h80, 8'h7E), mkrow(8'h01, 8'h33), 1'b1);
    endtask

    task automatic t_full_bytes();
        for (int b = 0; b < 16; b++) begin
            logic [7:0] m = 8'(b * 37 + 5);
            send(mkrow(m, 8'(b)), (b % 3 == 0) ? mkrow(m, 8'h55) : mkrow(~m, 8'h09), 1'b0);
        end
    endtask

    task automatic t_flush_partial();
        send(mkrow(8'h0F, 8'h02), mkrow(8'h0F, 8'h03), 1'b0);
        send(mkrow(8'h11, 8'h04), mkrow(8'h22, 8'h05), 1'b0);
        send(mkrow(8'hC0, 8'h06), mkrow(8'hC0, 8'h07), 1'b1);
        send(mkrow(8'h01, 8'h08), mkrow(8'h01, 8'h09), 1'b1);
    endtask

    task automatic t_coincide();
        for (int b = 0; b < 8; b++)
            send(mkrow(8'(b + 1), 8'h20), mkrow(8'(b + 1 + (b & 1)), 8'h30), b == 7);
        send(mkrow(8'hF0, 8'h0A), mkrow(8'hF0, 8'h0B), 1'b1);
    endtask

    task automatic t_stall();
        for (int i = 0; i < 4; i++) begin
            blk_row_a = mkrow(8'hFF, 8'h11); blk_row_b = '0; blk_last = 1'b1;
            @(negedge clk);
            chk(ind_we == 1'b0, "R11 idle no write", 64'(ind_we), 64'd0);
            chk(val_cnt == '0, "R11 idle no values", 64'(val_cnt), 64'd0);
            chk(mark_vld == 1'b0, "R11 idle no mark", 64'(mark_vld), 64'd0);
        end
        blk_last = 1'b0;
        send(mkrow(8'h66, 8'h12), mkrow(8'h66, 8'h13), 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_patterns();
        t_full_bytes();
        t_flush_partial();
        t_coincide();
        t_stall();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule